// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 11-bit fetch address of a small microcontroller core and decides, once per instruction cycle, where the next fetch comes from. A strobe marks each instruction-cycle boundary; the counter moves only on that strobe. On a plain cycle it steps by one. Otherwise the new address comes from one of these: a taken skip (two ahead), a write of the low address byte (a jump inside the current 256-word page), a jump or call target taken from the instruction operand, a return address from the top of the stack, or a fixed vector for one of four interrupt sources. Synchronous reset clears the address to zero.

Every change of flow costs one extra instruction cycle. During that cycle the word fetched before the change is thrown away. The block raises a flag for that cycle and ignores any request presented in it. On a call or an accepted interrupt it puts the return address on a push port for the stack. It also returns a one-hot acknowledge for the interrupt it took. The stack, the interrupt enable logic and the decoder sit outside and drive the request inputs.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc` becomes 0x000 and `flush` becomes 0 on that edge, whatever the strobe, interrupt and request inputs are.
- R2: A strobe with no request and `flush` low sets `pc` to `pc + 1` modulo 2^11, so 0x7FF steps to 0x000.
- R3: With `cyc_stb` low, `pc` and `flush` hold their values. `irq_ack` and `push_en` stay 0 whatever the other inputs are.
- R4: `irq_req` bit 0 selects vector 0x004, bit 1 selects 0x008, bit 2 selects 0x00C and bit 3 selects 0x010. The lowest set bit wins. Any interrupt wins over the `xfer_req` request. `irq_ack` is one-hot on the bit that was taken, during the strobe cycle only.
- R5: `xfer_req` = 3'd1 (taken skip) sets `pc` to `pc + 2` modulo 2^11.
- R6: `xfer_req` = 3'd2 (low-byte write) sets `pc` to {`pc`[10:8], `wr_data`}.
- R7: `xfer_req` = 3'd3 (jump) and 3'd4 (call) load `pc` from `operand`. 3'd5 (return) loads `pc` from `stack_top`. Codes 3'd0, 3'd6 and 3'd7 act as no request.
- R8: On a strobe that takes a call or an interrupt, `push_en` is 1 and `push_addr` equals the current `pc`. Otherwise `push_en` is 0.
- R9: Every transfer (skip, low-byte write, jump, call, return, interrupt) sets `flush` to 1 until the next strobe. At that strobe `pc` steps by one, `flush` clears, and the `xfer_req` and `irq_req` inputs have no effect.
- R10: `pc_low` always equals `pc`[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Instruction-cycle boundary strobe |
| xfer_req | input | 3 | Decoded transfer request code |
| operand | input | 11 | Jump or call target from the instruction |
| wr_data | input | 8 | Byte written to the low address register |
| stack_top | input | 11 | Return address at the top of the stack |
| irq_req | input | 4 | Interrupt requests, bit 0 has the highest priority |
| pc | output | 11 | Current fetch address |
| pc_low | output | 8 | Readable low byte of the fetch address |
| flush | output | 1 | High during the dummy cycle after a transfer |
| irq_ack | output | 4 | One-hot acknowledge of the interrupt taken |
| push_en | output | 1 | Push the return address onto the stack |
| push_addr | output | 11 | Return address to push |

## Verification
The assertions assume that `rst_n` is low at the first rising edge. They also assume `cyc_stb` is a single-cycle pulse, so the request inputs are only meaningful in a strobe cycle. The bench drives the strobe as one-clock pulses with idle clocks in between. It holds reset low for the first edges and sets the request inputs only at falling edges. In one idle clock it presents live requests on purpose, to show they are ignored.

// File: rtl/pcseq_pkg.sv
// pcseq_pkg: shared sizes and the transfer request encoding.
// Assumes the decoder drives xfer_req with one of these codes.
package pcseq_pkg;
    localparam int PC_W_DEF   = 11;
    localparam int BYTE_W_DEF = 8;
    localparam int N_IRQ_DEF  = 4;
    localparam int VEC_STEP_DEF = 4;

    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_SKIP = 3'd1,
        XF_LOWB = 3'd2,
        XF_JUMP = 3'd3,
        XF_CALL = 3'd4,
        XF_RET  = 3'd5
    } xfer_e;
endpackage

// File: rtl/pcseq_irq_pick.sv
// pcseq_irq_pick: fixed-priority pick among interrupt requests.
// Lowest index wins. Vector of index i is (i+1)*VEC_STEP.
// Assumes N_IRQ*VEC_STEP fits in PC_W bits.
module pcseq_irq_pick #(
    parameter int N_IRQ    = 4,
    parameter int PC_W     = 11,
    parameter int VEC_STEP = 4
) (
    input  logic [N_IRQ-1:0] req,
    output logic             hit,
    output logic [N_IRQ-1:0] onehot,
    output logic [PC_W-1:0]  vector
);
    logic [PC_W-1:0] vec_tab [N_IRQ];

    // One constant vector per source.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
        assign vec_tab[i] = PC_W'((i + 1) * VEC_STEP);
    end

    // Scan from the lowest priority up so that the lowest set index is kept.
    always_comb begin
        hit    = 1'b0;
        onehot = '0;
        vector = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit    = 1'b1;
                onehot = N_IRQ'(1) << i;
                vector = vec_tab[i];
            end
        end
    end
endmodule

// File: rtl/pcseq_next_sel.sv
// pcseq_next_sel: chooses the next fetch address for one strobe.
// Assumes: interrupt pick already done. During the dummy cycle all requests
// are dropped and the address just steps by one.
module pcseq_next_sel
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 11,
    parameter int BYTE_W = 8
) (
    input  logic [PC_W-1:0]   pc_cur,
    input  logic              in_dummy,
    input  logic [2:0]        kind,
    input  logic [PC_W-1:0]   operand,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PC_W-1:0]   stack_top,
    input  logic              irq_hit,
    input  logic [PC_W-1:0]   irq_vec,
    output logic [PC_W-1:0]   pc_next,
    output logic              is_xfer,
    output logic              want_push,
    output logic              irq_take
);
    localparam int HI_W = PC_W - BYTE_W;

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_skip;
    logic [PC_W-1:0] pc_page;

    // Candidate addresses.
    always_comb begin
        pc_inc  = pc_cur + PC_W'(1);
        pc_skip = pc_cur + PC_W'(2);
        pc_page = {pc_cur[PC_W-1 -: HI_W], wr_data};
    end

    // Priority: interrupt, then decoded request, then increment.
    always_comb begin
        pc_next   = pc_inc;
        is_xfer   = 1'b0;
        want_push = 1'b0;
        irq_take  = 1'b0;
        if (!in_dummy) begin
            if (irq_hit) begin
                pc_next   = irq_vec;
                is_xfer   = 1'b1;
                want_push = 1'b1;
                irq_take  = 1'b1;
            end else begin
                case (kind)
                    XF_SKIP: begin pc_next = pc_skip;   is_xfer = 1'b1; end
                    XF_LOWB: begin pc_next = pc_page;   is_xfer = 1'b1; end
                    XF_JUMP: begin pc_next = operand;   is_xfer = 1'b1; end
                    XF_CALL: begin
                        pc_next   = operand;
                        is_xfer   = 1'b1;
                        want_push = 1'b1;
                    end
                    XF_RET:  begin pc_next = stack_top; is_xfer = 1'b1; end
                    default: begin pc_next = pc_inc; end
                endcase
            end
        end
    end
endmodule

// File: rtl/pcseq_pc_reg.sv
// pcseq_pc_reg: the program counter and the dummy-cycle flag.
// Assumes cyc_stb is a one-clock pulse per instruction cycle; reset is
// synchronous and active low.
module pcseq_pc_reg #(
    parameter int PC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic [PC_W-1:0] pc_next,
    input  logic            is_xfer,
    output logic [PC_W-1:0] pc_q,
    output logic            dummy_q
);
    // Load the new address and dummy flag on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            dummy_q <= 1'b0;
        end else if (cyc_stb) begin
            pc_q    <= pc_next;
            dummy_q <= is_xfer;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && !dummy_q));

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ($stable(pc_q) && $stable(dummy_q)));

    // R9
    dummy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && dummy_q) |=> (!dummy_q && pc_q == $past(pc_q) + PC_W'(1)));
endmodule

// File: rtl/pc_sequencer.sv
// pc_sequencer: program counter unit of a small microcontroller core.
// Picks the next fetch address each instruction-cycle strobe, inserts a
// dummy cycle after every transfer and offers the return address to the stack.
// Assumes an external decoder, stack and interrupt enable logic.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W     = PC_W_DEF,
    parameter int BYTE_W   = BYTE_W_DEF,
    parameter int N_IRQ    = N_IRQ_DEF,
    parameter int VEC_STEP = VEC_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic [2:0]        xfer_req,
    input  logic [PC_W-1:0]   operand,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PC_W-1:0]   stack_top,
    input  logic [N_IRQ-1:0]  irq_req,
    output logic [PC_W-1:0]   pc,
    output logic [BYTE_W-1:0] pc_low,
    output logic              flush,
    output logic [N_IRQ-1:0]  irq_ack,
    output logic              push_en,
    output logic [PC_W-1:0]   push_addr
);
    logic              irq_hit;
    logic [N_IRQ-1:0]  irq_onehot;
    logic [PC_W-1:0]   irq_vec;
    logic [PC_W-1:0]   pc_next;
    logic              is_xfer;
    logic              want_push;
    logic              irq_take;
    logic [PC_W-1:0]   pc_q;
    logic              dummy_q;

    pcseq_irq_pick #(.N_IRQ(N_IRQ), .PC_W(PC_W), .VEC_STEP(VEC_STEP)) pick_i (
        .req    (irq_req),
        .hit    (irq_hit),
        .onehot (irq_onehot),
        .vector (irq_vec)
    );

    pcseq_next_sel #(.PC_W(PC_W), .BYTE_W(BYTE_W)) sel_i (
        .pc_cur    (pc_q),
        .in_dummy  (dummy_q),
        .kind      (xfer_req),
        .operand   (operand),
        .wr_data   (wr_data),
        .stack_top (stack_top),
        .irq_hit   (irq_hit),
        .irq_vec   (irq_vec),
        .pc_next   (pc_next),
        .is_xfer   (is_xfer),
        .want_push (want_push),
        .irq_take  (irq_take)
    );

    pcseq_pc_reg #(.PC_W(PC_W)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .pc_next (pc_next),
        .is_xfer (is_xfer),
        .pc_q    (pc_q),
        .dummy_q (dummy_q)
    );

    // Drive outputs; side effects only in a live strobe cycle.
    always_comb begin
        pc        = pc_q;
        pc_low    = pc_q[BYTE_W-1:0];
        flush     = dummy_q;
        push_addr = pc_q;
        push_en   = rst_n && cyc_stb && want_push;
        irq_ack   = (rst_n && cyc_stb && irq_take) ? irq_onehot : '0;
    end

    // R4
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |-> (irq_ack == '0 && !push_en));

    // R8
    push_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> flush);

    // R6
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !flush && irq_req == '0 && xfer_req == XF_LOWB)
        |=> (pc == {$past(pc[PC_W-1:BYTE_W]), $past(wr_data)}));

    // R4
    irq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !flush && irq_req != '0) |=> (flush && pc[1:0] == 2'b00));
endmodule

// File: tb/pc_sequencer_tb.sv
// Scoreboard bench: driver pushes expected states, monitor compares them.
module pc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic [2:0]  xfer_req = 3'd0;
    logic [10:0] operand = '0;
    logic [7:0]  wr_data = '0;
    logic [10:0] stack_top = '0;
    logic [3:0]  irq_req = '0;
    logic [10:0] pc;
    logic [7:0]  pc_low;
    logic        flush;
    logic [3:0]  irq_ack;
    logic        push_en;
    logic [10:0] push_addr;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [10:0] pc;
        logic        fl;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [10:0] m_pc = '0;
    logic        m_dummy = 1'b0;
    logic        stb_d = 1'b0;

    always #10 clk = ~clk;

    pc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .xfer_req(xfer_req),
        .operand(operand), .wr_data(wr_data), .stack_top(stack_top),
        .irq_req(irq_req), .pc(pc), .pc_low(pc_low), .flush(flush),
        .irq_ack(irq_ack), .push_en(push_en), .push_addr(push_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: after each strobe edge, compare against the oldest expected item.
    always @(posedge clk) stb_d <= cyc_stb && rst_n;
    always @(negedge clk) begin
        if (stb_d && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(pc == e.pc, {e.tag, " pc"}, int'(pc), int'(e.pc));
            chk(flush == e.fl, {e.tag, " R9 flush"}, int'(flush), int'(e.fl));
            chk(pc_low == e.pc[7:0], {e.tag, " R10 pc_low"}, int'(pc_low), int'(e.pc[7:0]));
        end
    end

    // Driver: apply one strobe, model the result, check the same-cycle outputs.
    task automatic step(input logic [2:0] k, input logic [10:0] op, input logic [7:0] d,
                        input logic [10:0] st, input logic [3:0] irq, input string tag);
        logic [10:0] nx;
        logic        xf;
        logic        ps;
        logic [3:0]  ak;
        exp_t        e;
        @(negedge clk);
        xfer_req = k; operand = op; wr_data = d; stack_top = st; irq_req = irq;
        cyc_stb = 1'b1;
        nx = m_pc + 11'd1; xf = 1'b0; ps = 1'b0; ak = 4'd0;
        if (!m_dummy) begin
            if (irq != 4'd0) begin
                for (int i = 3; i >= 0; i--)
                    if (irq[i]) begin nx = 11'((i + 1) * 4); ak = 4'd1 << i; end
                xf = 1'b1; ps = 1'b1;
            end else begin
                case (k)
                    3'd1: begin nx = m_pc + 11'd2; xf = 1'b1; end
                    3'd2: begin nx = {m_pc[10:8], d}; xf = 1'b1; end
                    3'd3: begin nx = op; xf = 1'b1; end
                    3'd4: begin nx = op; xf = 1'b1; ps = 1'b1; end
                    3'd5: begin nx = st; xf = 1'b1; end
                    default: ;
                endcase
            end
        end
        #2;
        chk(push_en == ps, {tag, " R8 push_en"}, int'(push_en), int'(ps));
        if (ps) chk(push_addr == m_pc, {tag, " R8 push_addr"}, int'(push_addr), int'(m_pc));
        chk(irq_ack == ak, {tag, " R4 irq_ack"}, int'(irq_ack), int'(ak));
        e.pc = nx; e.fl = xf; e.tag = tag;
        exp_q.push_back(e);
        m_pc = nx; m_dummy = xf;
        @(negedge clk);
        cyc_stb = 1'b0; xfer_req = 3'd0; irq_req = 4'd0;
    endtask

    task automatic go(input logic [10:0] addr);
        step(3'd3, addr, 8'h00, 11'h0, 4'd0, "R7 jump");
        step(3'd0, 11'h0, 8'h00, 11'h0, 4'd0, "R9 dummy");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(pc == 11'h000, "R1 reset pc", int'(pc), 0);
        chk(flush == 1'b0, "R1 reset flush", int'(flush), 0);
        rst_n = 1'b1;

        step(3'd0, 0, 0, 0, 0, "R2 inc");
        step(3'd0, 0, 0, 0, 0, "R2 inc");
        step(3'd6, 11'h555, 0, 0, 0, "R7 code6 none");
        step(3'd3, 11'h123, 0, 0, 0, "R7 jump");
        step(3'd3, 11'h555, 0, 0, 4'b0001, "R9 dummy ignores");
        step(3'd2, 0, 8'h9A, 0, 0, "R6 low byte");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd1, 0, 0, 0, 0, "R5 skip");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd4, 11'h7F0, 0, 0, 0, "R7 R8 call");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd5, 0, 0, 11'h0AB, 0, "R7 return");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd3, 11'h300, 0, 0, 4'b1100, "R4 irq over jump");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd0, 0, 0, 0, 4'b0001, "R4 ext vector");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd0, 0, 0, 0, 4'b1010, "R4 timer vector");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        step(3'd0, 0, 0, 0, 4'b1000, "R4 last vector");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        go(11'h7FE);
        step(3'd0, 0, 0, 0, 0, "R2 wrap");
        go(11'h7FD);
        step(3'd1, 0, 0, 0, 0, "R5 skip wrap");
        step(3'd0, 0, 0, 0, 0, "R9 dummy");
        go(11'h4F0);
        step(3'd2, 0, 8'h05, 0, 0, "R6 page keep");

        // R3: live requests without a strobe change nothing.
        @(negedge clk);
        xfer_req = 3'd4; operand = 11'h111; irq_req = 4'b0001;
        #2;
        chk(irq_ack == 4'd0, "R3 idle ack", int'(irq_ack), 0);
        chk(push_en == 1'b0, "R3 idle push", int'(push_en), 0);
        @(negedge clk);
        chk(pc == m_pc, "R3 idle pc", int'(pc), int'(m_pc));
        chk(flush == m_dummy, "R3 idle flush", int'(flush), int'(m_dummy));
        xfer_req = 3'd0; irq_req = 4'd0;

        // R1: reset beats a strobe with an interrupt.
        @(negedge clk);
        rst_n = 1'b0; cyc_stb = 1'b1; irq_req = 4'b0100;
        @(negedge clk);
        chk(pc == 11'h000, "R1 reset priority pc", int'(pc), 0);
        chk(flush == 1'b0, "R1 reset priority flush", int'(flush), 0);
        cyc_stb = 1'b0; irq_req = 4'd0; rst_n = 1'b1;
        m_pc = '0; m_dummy = 1'b0;
        step(3'd0, 0, 0, 0, 0, "R2 after reset");
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule